// File: doc/BRIEF.md
# Rate-Scaled Multi-Stage FIFO Channel

This block carries data words across a long on-chip link. The link is built as a series of small synchronous FIFO stages. All stages run from one physical clock. Each interior stage may run at a lower effective rate, and it advances only on cycles that a programmable integer divider marks as active. The first and last stages always run at the full clock rate, so the producer and consumer see an undivided interface. The depth of each stage is set by a parameter. The entry and exit stages can be made deeper to win back the throughput lost when the interior stages are slowed.

A word moves from one stage to the next only when the upstream stage is active and holds data, and the downstream stage is active and has room. A stage that is full accepts a new word only in a cycle in which it also releases one. No word is ever dropped: it waits where it is until space opens downstream. The producer uses a valid/ready push port and the consumer uses a valid/ready pop port. Two counters report how many words were accepted at the input and how many were delivered at the output, so the throughput can be measured over any window.

Top module: `rate_fifo_chain`

## Requirements
- R1: Every accepted word is delivered exactly once, in the order in which it was accepted.
- R2: A synchronous active-high reset empties all stages, zeroes both counters and restarts every divider. In the cycle after reset, out_valid is 0 and in_ready is 1.
- R3: No stage ever takes a word while full unless it releases one in the same cycle. With the sink stalled, the channel accepts exactly the sum of its stage depths (13 for the bench configuration of 4/2/2/5).
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged.
- R5: With a divide factor of 1, a word accepted at clock edge t raises out_valid after edge t+NSTAGE-1, where the bench uses NSTAGE = 4.
- R6: With a divide factor of 1 and the sink always ready, in_ready never drops during a continuous burst of words.
- R7: Interior stages advance once every N cycles, where N is the value of div_i. A div_i of 0 acts as 1. With the source and sink always ready, the channel delivers exactly one word every N cycles in steady state.
- R8: An in_valid offered while in_ready is 0 is not accepted, and an out_ready while out_valid is 0 delivers nothing. Neither event changes the counters.
- R9: acc_count counts input handshakes and dlv_count counts output handshakes since the last reset.
- R10: The first stage always runs at full rate. Even with a large divide factor, it takes its full depth of words back to back without stalling the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | DIV_W | Divide factor for the interior stages (0 is treated as 1) |
| in_valid | input | 1 | Source offers a word |
| in_data | input | WIDTH | Word offered by the source |
| in_ready | output | 1 | Channel takes the offered word at this edge |
| out_valid | output | 1 | Channel holds a word for the sink |
| out_data | output | WIDTH | Oldest word in the channel |
| out_ready | input | 1 | Sink takes the word at this edge |
| acc_count | output | CNT_W | Number of words accepted since reset |
| dlv_count | output | CNT_W | Number of words delivered since reset |

## Verification
The embedded properties assume that every input is a known value from the first cycle after reset. They also assume that the sink's out_ready is the only thing that lets the exit stage release a word. The stimulus drives every input at the falling clock edge. It changes div_i only after the channel has drained, so each measurement window sees a single, fixed divider period that is in phase across all interior stages. Output words are compared against a queue of the words actually accepted, so any loss, duplication or reordering shows up as a mismatch.

// File: rtl/chan_pkg.sv
package chan_pkg;

  // Depth of stage idx in a chain of n stages: the entry and exit stages take
  // their own depths, and every interior stage shares one.
  function automatic int stage_depth(input int idx, input int n,
                                     input int d_in, input int d_mid,
                                     input int d_out);
    if (idx == 0)
      return d_in;
    else if (idx == n - 1)
      return d_out;
    else
      return d_mid;
  endfunction

endpackage

// File: rtl/rate_tick.sv
module rate_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // A divide value of zero behaves like one (full rate).
  assign limit  = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (cnt >= limit)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i > 1) |=> !tick_o);

endmodule

// File: rtl/chan_stage.sv
module chan_stage #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage has no reset so that it can map onto RAM.
  always_ff @(posedge clk) begin
    if (push_i)
      mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_i) wptr <= bump(wptr);
      if (pop_i)  rptr <= bump(rptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign data_o  = mem[rptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |-> !full_o);

  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);

endmodule

// File: rtl/rate_fifo_chain.sv
module rate_fifo_chain #(
  parameter int WIDTH     = 16,
  parameter int NSTAGE    = 3,
  parameter int DEPTH_IN  = 3,
  parameter int DEPTH_MID = 3,
  parameter int DEPTH_OUT = 3,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready,
  output logic [CNT_W-1:0] acc_count,
  output logic [CNT_W-1:0] dlv_count
);

  localparam int LAST = NSTAGE - 1;

  for (genvar k = 0; k < NSTAGE; k++) begin : st
    logic             en_w, take_w, pop_w, push_w, empty_w, full_w;
    logic [WIDTH-1:0] q_w, din_w;

    // Entry and exit stages always run at full rate; interior ones are divided.
    if (k == 0 || k == LAST) begin : g_full
      assign en_w = 1'b1;
    end else begin : g_slow
      rate_tick #(.DIV_W(DIV_W)) tick_i (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_i),
        .tick_o (en_w)
      );
    end

    // A word leaves only if the next stage (or the sink) takes it.
    if (k == LAST) begin : g_tail
      assign pop_w = en_w & ~empty_w & out_ready;
    end else begin : g_body
      assign pop_w = en_w & ~empty_w & st[k+1].take_w;
    end

    if (k == 0) begin : g_head
      assign push_w = in_valid & take_w;
      assign din_w  = in_data;
    end else begin : g_link
      assign push_w = st[k-1].pop_w;
      assign din_w  = st[k-1].q_w;
    end

    // Room exists when not full, or when full but releasing a word this cycle.
    assign take_w = en_w & (~full_w | pop_w);

    chan_stage #(
      .WIDTH (WIDTH),
      .DEPTH (chan_pkg::stage_depth(k, NSTAGE, DEPTH_IN, DEPTH_MID, DEPTH_OUT))
    ) fifo_i (
      .clk         (clk),
      .rst         (rst),
      .push_i      (push_w),
      .push_data_i (din_w),
      .pop_i       (pop_w),
      .data_o      (q_w),
      .empty_o     (empty_w),
      .full_o      (full_w)
    );
  end

  assign in_ready  = st[0].take_w;
  assign out_valid = ~st[LAST].empty_w;
  assign out_data  = st[LAST].q_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_count <= '0;
      dlv_count <= '0;
    end else begin
      if (in_valid && in_ready)   acc_count <= acc_count + 1'b1;
      if (out_valid && out_ready) dlv_count <= dlv_count + 1'b1;
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/rate_fifo_chain_tb_top.sv
`timescale 1ns/1ps
module rate_fifo_chain_tb_top;

  localparam int WIDTH = 16;
  localparam int NST   = 4;
  localparam int D_IN  = 4;
  localparam int D_MID = 2;
  localparam int D_OUT = 5;
  localparam int CAP   = D_IN + 2 * D_MID + D_OUT;

  logic             clk = 1'b0;
  logic             rst;
  logic [7:0]       div_i;
  logic             in_valid;
  logic [WIDTH-1:0] in_data;
  logic             in_ready;
  logic             out_valid;
  logic [WIDTH-1:0] out_data;
  logic             out_ready;
  logic [31:0]      acc_count, dlv_count;

  int checks = 0;
  int errors = 0;
  int stalls = 0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] sb[$];

  always #10 clk = ~clk;

  rate_fifo_chain #(
    .WIDTH(WIDTH), .NSTAGE(NST), .DEPTH_IN(D_IN), .DEPTH_MID(D_MID),
    .DEPTH_OUT(D_OUT), .DIV_W(8), .CNT_W(32)
  ) dut_i (
    .clk(clk), .rst(rst), .div_i(div_i), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready),
    .acc_count(acc_count), .dlv_count(dlv_count)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: offers a word and records it once the handshake is certain.
  task automatic push(input logic [WIDTH-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #5;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #5;
    end
    sb.push_back(d);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drain();
    for (int n = 0; n < 3000 && sb.size() != 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares every delivered word with the scoreboard (R1).
  always @(negedge clk) begin
    #5;
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0)
        check(1'b0, "R1 unexpected word", longint'(out_data), -1);
      else
        check(out_data == sb[0], "R1 order", longint'(out_data),
              longint'(sb[0]));
      if (sb.size() != 0) void'(sb.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    int acc0, dlv0;
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] nxt;

    rst = 1'b1; div_i = 8'd1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #5;
    // R2: reset state
    check(out_valid == 1'b0, "R2 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R2 in_ready", in_ready, 1);
    check(acc_count == 0 && dlv_count == 0, "R2 counters", acc_count, 0);

    // R5: latency at full rate
    out_ready = 1'b1;
    push(16'h0100);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check(lat == NST - 1, "R5 latency", lat, NST - 1);
    wait_drain();

    // R6 and R7: div_i of 0 behaves as full rate, no source stalls
    div_i = 8'd0;
    stalls = 0;
    for (int i = 0; i < 20; i++) push(16'h0200 + 16'(i));
    idle();
    check(stalls == 0, "R6 R7 full-rate burst stalls", stalls, 0);
    wait_drain();

    // R7: divide by 4 gives one word every four cycles
    div_i = 8'd4;
    fork
      begin
        for (int i = 0; i < 60; i++) push(16'h0300 + 16'(i));
        idle();
      end
    join_none
    repeat (30) @(negedge clk);
    dlv0 = dlv_count;
    repeat (40) @(negedge clk);
    check(dlv_count - dlv0 == 10, "R7 rate 1/4", dlv_count - dlv0, 10);
    wait fork;
    wait_drain();

    // R10: entry stage takes its depth back to back even when slowed heavily
    div_i = 8'd16;
    out_ready = 1'b0;
    stalls = 0;
    for (int i = 0; i < D_IN; i++) push(16'h0400 + 16'(i));
    idle();
    check(stalls == 0, "R10 entry stage stalls", stalls, 0);
    out_ready = 1'b1;
    wait_drain();

    // R3, R8, R9: capacity with the sink stalled; surplus offers are ignored
    div_i = 8'd1;
    out_ready = 1'b0;
    acc0 = acc_count;
    nxt = 16'h0500;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = nxt;
      #5;
      if (in_ready) begin
        sb.push_back(nxt);
        nxt = nxt + 1'b1;
      end
    end
    idle();
    #5;
    check(sb.size() == CAP, "R3 capacity", sb.size(), CAP);
    check(acc_count - acc0 == CAP, "R8 R9 acc_count", acc_count - acc0, CAP);
    check(in_ready == 1'b0, "R3 full in_ready", in_ready, 0);

    // R4: output held while the sink is stalled
    held = out_data;
    repeat (6) @(negedge clk);
    #5;
    check(out_valid == 1'b1 && out_data == held, "R4 hold",
          longint'(out_data), longint'(held));
    out_ready = 1'b1;
    wait_drain();

    // R8: ready without valid delivers nothing
    dlv0 = dlv_count;
    repeat (5) @(negedge clk);
    check(dlv_count == dlv0, "R8 empty pop", dlv_count, dlv0);

    // R2: reset in the middle of traffic discards stored words
    out_ready = 1'b0;
    for (int i = 0; i < 5; i++) push(16'h0600 + 16'(i));
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sb.delete();
    #5;
    check(out_valid == 1'b0, "R2 mid reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R2 mid reset in_ready", in_ready, 1);
    check(acc_count == 0 && dlv_count == 0, "R2 mid reset counters",
          acc_count, 0);
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) push(16'h0700 + 16'(i));
    idle();
    wait_drain();

    // R1, R9: everything delivered, counters agree
    check(sb.size() == 0, "R1 leftover words", sb.size(), 0);
    check(acc_count == 3, "R9 acc_count", acc_count, 3);
    check(dlv_count == 3, "R9 dlv_count", dlv_count, 3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule